// File: doc/BRIEF.md
# SD Command and Response Sequencer

This block runs one command exchange on the CMD line of an SD card bus. The host places a 16-bit command word and a 32-bit argument on its inputs and pulses `start`. The block builds the 48-bit command frame, including its CRC7, and shifts it out one bit per SD clock enable. It then listens for the card's reply.

The response-type field of the command word chooses how the reply is handled:

- no reply at all;
- a 48-bit reply with index and CRC checks;
- the same reply followed by a wait on DAT0 busy;
- a 136-bit reply;
- a 48-bit reply with no index or CRC check.

The captured reply is presented as four 32-bit words on a 128-bit bus. A one-cycle event marks the end of the reply. Four sticky error flags each report one failure class.

The SD clock itself is generated outside the block. `sd_clk_en` is a one-cycle strobe that stands for one SD clock period. The block changes `cmd_out` and samples `cmd_in` and `dat0_in` only on cycles where the strobe is high.

Top module: `sd_cmd_seq`

## Requirements
- R1: After reset, `busy`, `cmd_oe`, `resp_end` and all four error flags are 0, `cmd_out` is 1 and `resp` is all zeros.
- R2: A `start` pulse while `busy` is 0 is accepted, and `busy` is 1 from the next cycle until the operation ends. A `start` pulse while `busy` is 1 is ignored and does not change the frame being sent.
- R3: On 48 successive strobes, `cmd_out` carries the frame MSB first, with `cmd_oe` high for exactly those 48 bits. The frame is:
  - a 0 start bit and a 1 direction bit;
  - the index `cmd_word[5:0]`;
  - the 32-bit argument;
  - the CRC7 (polynomial x^7+x^3+1) over the preceding 40 bits;
  - a 1 end bit.
  Bit 6 of the command word (the application-command marker) does not alter the frame.
- R4: `cmd_word[10:8]` selects the reply handling:
  - 4: 48-bit reply, checked;
  - 5: 48-bit reply, checked, then busy wait;
  - 6: 136-bit reply, unchecked;
  - 7: 48-bit reply, unchecked.
  Any other value means no reply, and `busy` falls right after the end bit. For types 6 and 7 a wrong index or CRC raises no flag.
- R5: If `cmd_in` is still 1 on the 64th strobe after the end bit, `err_timeout` is set and `busy` falls. A start bit on the 64th strobe is still accepted.
- R6: `resp_end` pulses for one cycle on the strobe that samples the last reply bit. At that point `resp` is loaded:
  - for 48-bit replies, `resp[31:0]` holds reply bits 39:8 and the upper bits are 0;
  - for 136-bit replies, `resp[126:0]` holds reply bits 127:1 and `resp[127]` is 0.
- R7: For types 4 and 5, `err_index` is set when reply bits 45:40 differ from the sent index.
- R8: For types 4 and 5, `err_crc` is set when reply bits 7:1 differ from the CRC7 of reply bits 47:8.
- R9: For every reply type, `err_stop` is set when the last reply bit is 0.
- R10: For type 5, `busy` stays 1 after the reply until a strobe samples `dat0_in` as 1.
- R11: Error flags hold their value until the next accepted `start`, which clears all four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_clk_en | input | 1 | One-cycle strobe per SD clock period |
| start | input | 1 | Begin a command exchange |
| cmd_word | input | 16 | Index [5:0], app marker [6], reply type [10:8] |
| cmd_arg | input | 32 | Command argument |
| cmd_in | input | 1 | CMD line as seen from the card |
| dat0_in | input | 1 | DAT0 line, low while the card is busy |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line output enable |
| busy | output | 1 | Exchange in progress |
| resp_end | output | 1 | Reply fully received (one-cycle pulse) |
| err_index | output | 1 | Echoed index mismatch |
| err_crc | output | 1 | Reply CRC mismatch |
| err_stop | output | 1 | Reply end bit was 0 |
| err_timeout | output | 1 | No reply start bit within 64 strobes |
| resp | output | 128 | Captured reply, four 32-bit words |

## Verification
The following properties are checked on every cycle:
- the line is driven only while `busy` is high;
- `cmd_out` changes only on a strobe;
- `busy` rises only after an accepted `start`;
- `resp_end` is a single-cycle pulse;
- each reply error flag rises only together with `resp_end`;
- a timeout leaves the block idle;
- the busy wait ends only on a strobe that saw DAT0 high.

Only the bench scenarios can show the following:
- the frame bits and their CRC;
- the captured reply word layout;
- the exact 63/64-strobe timeout boundary;
- which response types suppress the index and CRC checks;
- that a `start` during a frame is ignored.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

   localparam int CMD_FRAME_BITS  = 48;
   localparam int SHORT_RESP_BITS = 48;
   localparam int LONG_RESP_BITS  = 136;
   localparam int CRC_SPAN_BITS   = 40;
   localparam int RESP_OUT_BITS   = 128;

   localparam logic [2:0] RT_SHORT    = 3'd4;
   localparam logic [2:0] RT_SHORT_BSY = 3'd5;
   localparam logic [2:0] RT_LONG     = 3'd6;
   localparam logic [2:0] RT_RAW      = 3'd7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_WAIT,
      ST_RECV,
      ST_HOLD
   } seq_state_t;

   function automatic logic [6:0] crc7_step(input logic [6:0] crc, input logic b);
      logic fb;
      fb = b ^ crc[6];
      return {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
   endfunction

   function automatic logic [6:0] crc7_over40(input logic [39:0] bits);
      logic [6:0] c;
      c = '0;
      for (int k = 39; k >= 0; k--) c = crc7_step(c, bits[k]);
      return c;
   endfunction

endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
   import sd_cmd_pkg::*;
#(
   parameter int FRAME_BITS = CMD_FRAME_BITS
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic        shift,
   input  logic [5:0]  idx,
   input  logic [31:0] arg,
   output logic        bit_out
);

   generate
      if (FRAME_BITS != 48) begin : g_bad_frame
         $error("sd_cmd_tx: FRAME_BITS must be 48");
      end
   endgenerate

   logic [FRAME_BITS-1:0] sh;
   logic [39:0]           head;

   assign head    = {2'b01, idx, arg};
   assign bit_out = sh[FRAME_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '1;
      else if (load)  sh <= {head, crc7_over40(head), 1'b1};
      else if (shift) sh <= {sh[FRAME_BITS-2:0], 1'b1};
   end

   assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bit_out == 1'b0));

endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
   import sd_cmd_pkg::*;
#(
   parameter int MAX_BITS = LONG_RESP_BITS,
   parameter int CRC_BITS = CRC_SPAN_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                sample,
   input  logic                bit_in,
   output logic [MAX_BITS-1:0] sh,
   output logic [6:0]          crc,
   output logic [7:0]          cnt
);

   generate
      if (MAX_BITS > 255 || CRC_BITS >= MAX_BITS) begin : g_bad_rx
         $error("sd_cmd_rx: bad MAX_BITS/CRC_BITS");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         crc <= '0;
         cnt <= '0;
      end else if (clr) begin
         sh  <= '0;
         crc <= '0;
         cnt <= '0;
      end else if (sample) begin
         sh  <= {sh[MAX_BITS-2:0], bit_in};
         if (cnt < 8'(CRC_BITS)) crc <= crc7_step(crc, bit_in);
         cnt <= cnt + 8'd1;
      end
   end

   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= 8'(MAX_BITS));

endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
   import sd_cmd_pkg::*;
#(
   parameter int TIMEOUT_TICKS = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sd_clk_en,
   input  logic         start,
   input  logic [15:0]  cmd_word,
   input  logic [31:0]  cmd_arg,
   input  logic         cmd_in,
   input  logic         dat0_in,
   output logic         cmd_out,
   output logic         cmd_oe,
   output logic         busy,
   output logic         resp_end,
   output logic         err_index,
   output logic         err_crc,
   output logic         err_stop,
   output logic         err_timeout,
   output logic [127:0] resp
);

   localparam int TMO_W = $clog2(TIMEOUT_TICKS + 1);

   generate
      if (TIMEOUT_TICKS < 1) begin : g_bad_tmo
         $error("sd_cmd_seq: TIMEOUT_TICKS must be at least 1");
      end
   endgenerate

   seq_state_t                state;
   logic [15:0]               word_q;
   logic [5:0]                tx_cnt;
   logic [TMO_W-1:0]          tmo_cnt;
   logic                      tx_load, tx_shift, tx_bit;
   logic                      rx_sample;
   logic [LONG_RESP_BITS-1:0] rx_sh, fr_nx;
   logic [6:0]                rx_crc;
   logic [7:0]                rx_cnt;
   logic [2:0]                rtype;
   logic                      has_resp, is_long, checked, rx_last;

   assign rtype    = word_q[10:8];
   assign has_resp = rtype[2];
   assign is_long  = (rtype == RT_LONG);
   assign checked  = (rtype == RT_SHORT) || (rtype == RT_SHORT_BSY);
   assign tx_load  = (state == ST_IDLE) && start;
   assign tx_shift = (state == ST_SEND) && sd_clk_en;
   assign rx_sample = sd_clk_en && (((state == ST_WAIT) && !cmd_in) || (state == ST_RECV));
   assign rx_last  = (state == ST_RECV) &&
                     (rx_cnt == (is_long ? 8'(LONG_RESP_BITS - 1) : 8'(SHORT_RESP_BITS - 1)));
   assign fr_nx    = {rx_sh[LONG_RESP_BITS-2:0], cmd_in};

   assign busy    = (state != ST_IDLE);
   assign cmd_oe  = (state == ST_SEND);
   assign cmd_out = cmd_oe ? tx_bit : 1'b1;

   sd_cmd_tx u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tx_load),
      .shift   (tx_shift),
      .idx     (cmd_word[5:0]),
      .arg     (cmd_arg),
      .bit_out (tx_bit)
   );

   sd_cmd_rx u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (tx_load),
      .sample (rx_sample),
      .bit_in (cmd_in),
      .sh     (rx_sh),
      .crc    (rx_crc),
      .cnt    (rx_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         word_q      <= '0;
         tx_cnt      <= '0;
         tmo_cnt     <= '0;
         resp_end    <= 1'b0;
         err_index   <= 1'b0;
         err_crc     <= 1'b0;
         err_stop    <= 1'b0;
         err_timeout <= 1'b0;
         resp        <= '0;
      end else begin
         resp_end <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               state       <= ST_SEND;
               word_q      <= cmd_word;
               tx_cnt      <= '0;
               err_index   <= 1'b0;
               err_crc     <= 1'b0;
               err_stop    <= 1'b0;
               err_timeout <= 1'b0;
            end
            ST_SEND: if (sd_clk_en) begin
               if (tx_cnt == 6'(CMD_FRAME_BITS - 1)) begin
                  tmo_cnt <= '0;
                  state   <= has_resp ? ST_WAIT : ST_IDLE;
               end else begin
                  tx_cnt <= tx_cnt + 6'd1;
               end
            end
            ST_WAIT: if (sd_clk_en) begin
               if (!cmd_in) begin
                  state <= ST_RECV;
               end else if (tmo_cnt == TMO_W'(TIMEOUT_TICKS - 1)) begin
                  err_timeout <= 1'b1;
                  state       <= ST_IDLE;
               end else begin
                  tmo_cnt <= tmo_cnt + 1'b1;
               end
            end
            ST_RECV: if (sd_clk_en && rx_last) begin
               resp_end  <= 1'b1;
               err_index <= checked && (fr_nx[45:40] != word_q[5:0]);
               err_crc   <= checked && (fr_nx[7:1] != rx_crc);
               err_stop  <= !cmd_in;
               resp      <= is_long ? {1'b0, fr_nx[127:1]} : {96'b0, fr_nx[39:8]};
               state     <= (rtype == RT_SHORT_BSY) ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: if (sd_clk_en && dat0_in) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_oe_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> busy);
   assert_line_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_oe && $past(cmd_oe) && !$past(sd_clk_en)) |-> $stable(cmd_out));
   assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   assert_resp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resp_end |=> !resp_end);
   assert_timeout_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_timeout) |-> !busy);
   assert_hold_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state == ST_HOLD) && (state == ST_IDLE)) |-> $past(dat0_in && sd_clk_en));
   assert_index_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_index) |-> resp_end);
   assert_crc_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_crc) |-> resp_end);
   assert_stop_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_stop) |-> resp_end);

endmodule

// File: tb/tb_sd_cmd_seq.sv
module tb_sd_cmd_seq;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sd_clk_en = 1'b0;
   logic         start = 1'b0;
   logic [15:0]  cmd_word = '0;
   logic [31:0]  cmd_arg = '0;
   logic         cmd_in = 1'b1;
   logic         dat0_in = 1'b1;
   logic         cmd_out, cmd_oe, busy, resp_end;
   logic         err_index, err_crc, err_stop, err_timeout;
   logic [127:0] resp;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   sd_cmd_seq dut (
      .clk(clk), .rst_n(rst_n), .sd_clk_en(sd_clk_en), .start(start),
      .cmd_word(cmd_word), .cmd_arg(cmd_arg), .cmd_in(cmd_in), .dat0_in(dat0_in),
      .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .resp_end(resp_end),
      .err_index(err_index), .err_crc(err_crc), .err_stop(err_stop),
      .err_timeout(err_timeout), .resp(resp)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [6:0] ref_crc(input logic [39:0] msg);
      logic [46:0] m;
      m = {msg, 7'b0};
      for (int i = 46; i >= 7; i--)
         if (m[i]) m[i-:8] = m[i-:8] ^ 8'h89;
      return m[6:0];
   endfunction

   function automatic logic [47:0] ref_cmd(input logic [15:0] w, input logic [31:0] a);
      return {2'b01, w[5:0], a, ref_crc({2'b01, w[5:0], a}), 1'b1};
   endfunction

   function automatic logic [47:0] ref_r48(input logic [5:0] idx, input logic [31:0] pl,
                                           input bit bad_crc, input bit bad_stop);
      logic [6:0] c;
      c = ref_crc({2'b00, idx, pl}) ^ (bad_crc ? 7'h01 : 7'h00);
      return {2'b00, idx, pl, c, !bad_stop};
   endfunction

   task automatic do_tick(input bit cin, output bit cout, output bit oe, output bit ev);
      @(negedge clk);
      cout = cmd_out;
      oe = cmd_oe;
      cmd_in = cin;
      sd_clk_en = 1'b1;
      @(negedge clk);
      sd_clk_en = 1'b0;
      ev = resp_end;
      repeat ($urandom % 2) @(negedge clk);
   endtask

   task automatic send(input logic [15:0] w, input logic [31:0] a, input bit inject,
                       output logic [47:0] got, output bit oe_all);
      bit c, o, e;
      @(negedge clk);
      cmd_word = w; cmd_arg = a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2", "busy after start", 128'(busy), 128'd1);
      oe_all = 1'b1;
      got = '0;
      for (int i = 0; i < 48; i++) begin
         if (inject && i == 10) begin
            @(negedge clk);
            cmd_word = ~w; cmd_arg = ~a; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
         do_tick(1'b1, c, o, e);
         got = {got[46:0], c};
         oe_all &= o;
      end
   endtask

   task automatic respond(input int gap, input int len, input logic [135:0] fr, output bit ev);
      bit c, o, e;
      ev = 1'b0;
      for (int i = 0; i < gap; i++) do_tick(1'b1, c, o, e);
      for (int i = 0; i < len; i++) begin
         do_tick(fr[len-1-i], c, o, e);
         ev = e;
      end
      cmd_in = 1'b1;
   endtask

   task automatic exercise(input logic [15:0] w, input logic [31:0] a, input bit inject,
                           input int gap, input int len, input logic [135:0] fr,
                           input logic [127:0] exp_r, input logic [3:0] exp_err,
                           input string req);
      logic [47:0] got;
      bit oe_all, ev;
      send(w, a, inject, got, oe_all);
      chk(got == ref_cmd(w, a), req, "command frame", 128'(got), 128'(ref_cmd(w, a)));
      chk(oe_all, "R3", "cmd_oe during frame", 128'(oe_all), 128'd1);
      if (w[10]) begin
         respond(gap, len, fr, ev);
         if (len > 0) begin
            chk(ev == 1'b1, "R6", "resp_end on last bit", 128'(ev), 128'd1);
            chk(resp == exp_r, req, "resp words", resp, exp_r);
         end
      end
      chk(cmd_oe == 1'b0, "R3", "cmd_oe after frame", 128'(cmd_oe), 128'd0);
      chk({err_index, err_crc, err_stop, err_timeout} == exp_err, req,
          "error flags {idx,crc,stop,tmo}",
          128'({err_index, err_crc, err_stop, err_timeout}), 128'(exp_err));
      if (w[10:8] != 3'd5)
         chk(busy == 1'b0, req, "busy after operation", 128'(busy), 128'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [47:0]  f48;
      logic [126:0] content;
      logic [31:0]  pl, a;
      logic [5:0]   idx;
      bit           c, o, e;
      int           t;
      int unsigned  seed;
      seed = $urandom(32'd20240611);

      repeat (3) @(negedge clk);
      chk({busy, cmd_oe, resp_end, err_index, err_crc, err_stop, err_timeout} == 7'b0,
          "R1", "reset outputs", 128'({busy, cmd_oe, resp_end}), 128'd0);
      chk(cmd_out == 1'b1, "R1", "cmd_out idle", 128'(cmd_out), 128'd1);
      chk(resp == '0, "R1", "resp reset", resp, 128'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3/R4: no-response command, known frame CRC (0x4A)
      exercise(16'h0300, 32'h0, 1'b0, 0, 0, '0, '0, 4'b0000, "R4");
      chk(ref_cmd(16'h0300, 32'h0) == 48'h400000000095, "R3", "reference frame",
          128'(ref_cmd(16'h0300, 32'h0)), 128'h400000000095);
      // R3: app marker bit 6 does not alter frame; type 0 means no reply
      exercise(16'h0069, 32'hA5A5_0F0F, 1'b0, 0, 0, '0, '0, 4'b0000, "R3");

      // R2: start while busy is ignored
      exercise(16'h0311, 32'h1234_5678, 1'b1, 0, 0, '0, '0, 4'b0000, "R2");

      // random mix of checked, long and unchecked replies
      for (int n = 0; n < 24; n++) begin
         t   = $urandom % 3;
         idx = 6'($urandom);
         a   = $urandom;
         pl  = $urandom;
         if (t == 0) begin
            f48 = ref_r48(idx, pl, 1'b0, 1'b0);
            exercise({5'b0, 3'd4, 2'b0, idx}, a, 1'b0, $urandom % 40, 48, 136'(f48),
                     {96'b0, pl}, 4'b0000, "R6");
         end else if (t == 1) begin
            content = {$urandom, $urandom, $urandom, $urandom};
            exercise({5'b0, 3'd6, 2'b0, idx}, a, 1'b0, $urandom % 40, 136,
                     {2'b00, 6'h3F, content, 1'b1}, {1'b0, content}, 4'b0000, "R6");
         end else begin
            f48 = {2'b00, 6'h3F, pl, 7'h7F, 1'b1};
            exercise({5'b0, 3'd7, 2'b0, idx}, a, 1'b0, $urandom % 40, 48, 136'(f48),
                     {96'b0, pl}, 4'b0000, "R4");
         end
      end

      // R7: wrong echoed index on a checked type
      f48 = ref_r48(6'd9, 32'hCAFE_0001, 1'b0, 1'b0);
      exercise(16'h0411, 32'h1, 1'b0, 3, 48, 136'(f48), {96'b0, 32'hCAFE_0001}, 4'b1000, "R7");
      // R11: next accepted command clears flags
      @(negedge clk);
      cmd_word = 16'h0300; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({err_index, err_crc, err_stop, err_timeout} == 4'b0, "R11", "flags cleared by start",
          128'({err_index, err_crc, err_stop, err_timeout}), 128'd0);
      for (int i = 0; i < 48; i++) do_tick(1'b1, c, o, e);

      // R8: bad CRC
      f48 = ref_r48(6'd17, 32'h0BAD_C0DE, 1'b1, 1'b0);
      exercise(16'h0411, 32'h2, 1'b0, 5, 48, 136'(f48), {96'b0, 32'h0BAD_C0DE}, 4'b0100, "R8");
      // R11: flags hold while idle
      repeat (5) @(negedge clk);
      chk(err_crc == 1'b1, "R11", "flag held while idle", 128'(err_crc), 128'd1);
      // R9: missing stop bit, checked type
      f48 = ref_r48(6'd17, 32'h7777_0000, 1'b0, 1'b1);
      exercise(16'h0411, 32'h3, 1'b0, 0, 48, 136'(f48), {96'b0, 32'h7777_0000}, 4'b0010, "R9");
      // R9: missing stop bit, long type
      content = {4{32'h1357_9BDF}};
      exercise(16'h0602, 32'h4, 1'b0, 2, 136, {2'b00, 6'h3F, content, 1'b0},
               {1'b0, content}, 4'b0010, "R9");
      // R4: unchecked type ignores index and CRC mismatch
      f48 = {2'b00, 6'h05, 32'h00FF_8000, 7'h00, 1'b1};
      exercise(16'h0729, 32'h5, 1'b0, 1, 48, 136'(f48), {96'b0, 32'h00FF_8000}, 4'b0000, "R4");

      // R5: start bit on the 64th strobe is accepted
      f48 = ref_r48(6'd13, 32'h6464_6464, 1'b0, 1'b0);
      exercise(16'h040D, 32'h6, 1'b0, 63, 48, 136'(f48), {96'b0, 32'h6464_6464}, 4'b0000, "R5");
      // R5: 64 idle strobes give timeout
      exercise(16'h040D, 32'h7, 1'b0, 64, 0, '0, '0, 4'b0001, "R5");

      // R10: busy wait on DAT0
      dat0_in = 1'b0;
      f48 = ref_r48(6'd7, 32'hB0B0_0007, 1'b0, 1'b0);
      exercise(16'h0507, 32'h8, 1'b0, 4, 48, 136'(f48), {96'b0, 32'hB0B0_0007}, 4'b0000, "R10");
      chk(busy == 1'b1, "R10", "busy held after reply", 128'(busy), 128'd1);
      repeat (5) do_tick(1'b1, c, o, e);
      chk(busy == 1'b1, "R10", "busy while DAT0 low", 128'(busy), 128'd1);
      dat0_in = 1'b1;
      do_tick(1'b1, c, o, e);
      chk(busy == 1'b0, "R10", "busy released by DAT0", 128'(busy), 128'd0);

      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule